// File: doc/BRIEF.md
# Bridge Deadlock Resolution Controller

This block makes the lock-resolution decision for a two-way bridge that links a processor bus with a PCI bus. The bridge can deadlock when the processor-side slave holds a stalled outbound cycle (processor to PCI) while inbound PCI traffic piles up behind it. The controller watches four things: how full the inbound write FIFO is, how much inbound read demand is queued, whether the PCI slave is busy with either, and whether an outbound cycle is stalled. From these it decides when the processor-side slave must give up its stalled cycle with a retry.

The condition that triggers resolution comes from a 2-bit mode field. It can be a separate 3-bit threshold for the write side and for the read side, any PCI-slave activity at all, or a completely full queue. The full-queue mode exists to stay compatible with older bridge behaviour.

The processor re-issues a compelled (non-posted) cycle after it has been retried. If the retried cycle was compelled and speculation is enabled, the block raises a speculative PCI bus request so that the PCI master already holds the bus when the cycle comes back. That request ends when the PCI master wins the bus for the re-issued cycle, or when a programmable timeout runs out.

Top module: `bridge_lock_resolver`

The controller is a three-state machine:

| State | Code | Meaning |
|-------|------|---------|
| IDLE | 0 | No outbound cycle is stalled. |
| ARMED | 1 | A stalled cycle is held and the trigger is being watched. |
| SPENT | 2 | The retry for this stalled cycle has already been issued. |

It has five transitions:

- **IDLE to ARMED**: a stall is present and the trigger is false.
- **IDLE to SPENT**: a stall is present and the trigger is true. This issues the retry.
- **ARMED to SPENT**: the trigger becomes true while the stall is held. This issues the retry.
- **ARMED to IDLE**: the stall goes away.
- **SPENT to IDLE**: the stall goes away.

In every other case the state holds.

## Requirements
- R1: With `cfg_mode_i` equal to 00 (threshold mode), or to 11 (reserved, handled as threshold mode), the trigger is true when either of these holds:
  - `slv_wr_act_i` is 1 and `wr_level_i` is at least `cfg_wr_thr_i` × DEPTH/8;
  - `slv_rd_act_i` is 1 and `rd_level_i` is at least `cfg_rd_thr_i` × DEPTH/8.
- R2: With `cfg_mode_i` equal to 01, the trigger is true whenever `slv_wr_act_i` or `slv_rd_act_i` is 1, whatever the levels are.
- R3: With `cfg_mode_i` equal to 10, the trigger is true only when an active side's level equals DEPTH. A level of DEPTH-1 does not fire.
- R4: `retry_o` is a one-cycle pulse. It is high in the cycle after the first clock edge at which `ob_stall_i` is 1, the trigger is true, and no retry has yet been issued for this stall.
- R5: Only one retry is issued per stalled transaction. A new retry becomes possible only after `ob_stall_i` has been sampled low and then rises again.
- R6: While `ob_stall_i` is 0, threshold crossings and slave activity cause neither a retry nor a speculative request.
- R7: `spec_req_o` rises together with `retry_o` only if `ob_compelled_i` and `cfg_spec_en_i` were both 1 at the resolving edge. Otherwise it does not rise.
- R8: While `spec_req_o` is high, sampling `pci_won_i` = 1 clears it on the next cycle, unless a new resolution is setting it at that same edge.
- R9: If the bus is never won, `spec_req_o` stays high for exactly `cfg_spec_tmo_i` cycles. A timeout value of 0 behaves as 1.
- R10: `state_o` shows the controller state after each edge, using IDLE = 0, ARMED = 1 and SPENT = 2, and follows the transitions listed above.
- R11: While `rst_ni` is low, `retry_o` and `spec_req_o` are 0 and `state_o` is IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_mode_i | input | 2 | Trigger mode: 00 threshold, 01 activity, 10 full, 11 threshold |
| cfg_wr_thr_i | input | 3 | Write-side threshold, in eighths of DEPTH |
| cfg_rd_thr_i | input | 3 | Read-side threshold, in eighths of DEPTH |
| cfg_spec_en_i | input | 1 | Enables the speculative PCI request |
| cfg_spec_tmo_i | input | TMO_W | Lifetime of the speculative request, in cycles |
| wr_level_i | input | LVL_W | Occupancy of the inbound write FIFO, 0..DEPTH |
| rd_level_i | input | LVL_W | Queued inbound read demand, 0..DEPTH |
| slv_wr_act_i | input | 1 | PCI slave is hosting an inbound write |
| slv_rd_act_i | input | 1 | PCI slave is hosting an inbound read |
| ob_stall_i | input | 1 | Processor-side slave holds a stalled outbound cycle |
| ob_compelled_i | input | 1 | The stalled cycle is compelled (non-posted) |
| pci_won_i | input | 1 | PCI master has won the bus for the re-issued cycle |
| retry_o | output | 1 | One-cycle retry/release strobe |
| spec_req_o | output | 1 | Speculative PCI bus request |
| state_o | output | 2 | Controller state |

## Verification
The bench builds the block with DEPTH = 16 and TMO_W = 4. This makes each threshold step two entries wide, so every level from empty to full, including the full/not-full edge at 15 and 16, is reachable in random stimulus. The narrow timeout field keeps speculative-request lifetimes to at most 15 cycles. As a result, expiry, a win that arrives before expiry, and a new resolution that arrives while a request is already pending all occur many times within a short run.

// File: rtl/lkr_pkg.sv
package lkr_pkg;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_ARMED = 2'd1,
        LK_SPENT = 2'd2
    } lk_state_e;

    typedef enum logic [1:0] {
        TRIG_THRESH   = 2'b00,
        TRIG_ACTIVITY = 2'b01,
        TRIG_FULL     = 2'b10,
        TRIG_RSVD     = 2'b11
    } trig_mode_e;

    localparam int unsigned NUM_CHAN = 2;
    localparam int unsigned CH_WR    = 0;
    localparam int unsigned CH_RD    = 1;

endpackage

// File: rtl/lkr_chan_cmp.sv
module lkr_chan_cmp
    import lkr_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LVL_W = $clog2(DEPTH) + 1
) (
    input  logic [1:0]       mode_i,
    input  logic [2:0]       thr_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             active_i,
    output logic             hit_o
);

    localparam int unsigned STEP = DEPTH / 8;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] thr_lvl;
    logic             ge_thr;
    logic             at_full;

    // The threshold is given in eighths of DEPTH.
    assign thr_lvl = LVL_W'(thr_i) * LVL_W'(STEP);
    assign ge_thr  = (level_i >= thr_lvl);
    assign at_full = (level_i >= FULL_LVL);

    always_comb begin
        hit_o = 1'b0;
        unique case (trig_mode_e'(mode_i))
            TRIG_THRESH:   hit_o = active_i && ge_thr;
            TRIG_ACTIVITY: hit_o = active_i;
            TRIG_FULL:     hit_o = active_i && at_full;
            TRIG_RSVD:     hit_o = active_i && ge_thr;
            default:       hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lkr_trigger.sv
module lkr_trigger
    import lkr_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LVL_W = $clog2(DEPTH) + 1
) (
    input  logic [1:0]                    mode_i,
    input  logic [NUM_CHAN-1:0][2:0]      thr_i,
    input  logic [NUM_CHAN-1:0][LVL_W-1:0] level_i,
    input  logic [NUM_CHAN-1:0]           active_i,
    output logic                          fire_o
);

    logic [NUM_CHAN-1:0] hit;

    // One comparator per inbound channel (write, read).
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        lkr_chan_cmp #(
            .DEPTH (DEPTH),
            .LVL_W (LVL_W)
        ) i_cmp (
            .mode_i   (mode_i),
            .thr_i    (thr_i[c]),
            .level_i  (level_i[c]),
            .active_i (active_i[c]),
            .hit_o    (hit[c])
        );
    end

    assign fire_o = |hit;

endmodule

// File: rtl/lkr_fsm.sv
module lkr_fsm
    import lkr_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      stall_i,
    input  logic      fire_i,
    output logic      resolve_o,
    output logic      retry_o,
    output lk_state_e state_o
);

    lk_state_e st_q;
    lk_state_e st_d;
    logic      retry_q;

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= LK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and the resolve decision.
    always_comb begin
        st_d      = st_q;
        resolve_o = 1'b0;
        unique case (st_q)
            LK_IDLE: begin
                if (stall_i) begin
                    if (fire_i) begin
                        resolve_o = 1'b1;
                        st_d      = LK_SPENT;
                    end else begin
                        st_d = LK_ARMED;
                    end
                end
            end
            LK_ARMED: begin
                if (!stall_i) begin
                    st_d = LK_IDLE;
                end else if (fire_i) begin
                    resolve_o = 1'b1;
                    st_d      = LK_SPENT;
                end
            end
            LK_SPENT: begin
                if (!stall_i) begin
                    st_d = LK_IDLE;
                end
            end
            default: st_d = LK_IDLE;
        endcase
    end

    // Registered outputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            retry_q <= 1'b0;
        end else begin
            retry_q <= resolve_o;
        end
    end

    assign retry_o = retry_q;
    assign state_o = st_q;

    p_retry_pulse_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_q |=> !retry_q);

    p_no_retry_unstalled_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stall_i |=> !retry_q);

    p_spent_once_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == LK_SPENT && stall_i) |=> (st_q == LK_SPENT && !retry_q));

    p_retry_enters_spent_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_q |-> st_q == LK_SPENT);

endmodule

// File: rtl/lkr_spec.sv
module lkr_spec #(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             resolve_i,
    input  logic             compelled_i,
    input  logic             spec_en_i,
    input  logic             won_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             spec_req_o
);

    localparam int unsigned CW = TMO_W + 1;

    logic             req_q;
    logic [TMO_W-1:0] cnt_q;
    logic             set;
    logic [CW-1:0]    cnt_inc;
    logic             expire;

    assign set     = resolve_i && compelled_i && spec_en_i;
    assign cnt_inc = {1'b0, cnt_q} + CW'(1);
    // A timeout of 0 gives the same one-cycle lifetime as a timeout of 1.
    assign expire  = (cnt_inc >= {1'b0, tmo_i});

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_q <= 1'b0;
            cnt_q <= '0;
        end else if (set) begin
            // A new resolution wins over a clear at the same edge.
            req_q <= 1'b1;
            cnt_q <= '0;
        end else if (req_q) begin
            if (won_i || expire) begin
                req_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_inc[TMO_W-1:0];
            end
        end
    end

    assign spec_req_o = req_q;

    p_spec_cause_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_q) |-> $past(compelled_i && spec_en_i && resolve_i));

    p_spec_win_drop_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_q && won_i && !resolve_i) |=> !req_q);

    p_spec_idle_hold_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_q && !resolve_i) |=> !req_q);

endmodule

// File: rtl/bridge_lock_resolver.sv
module bridge_lock_resolver
    import lkr_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned TMO_W = 8,
    parameter int unsigned LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       cfg_mode_i,
    input  logic [2:0]       cfg_wr_thr_i,
    input  logic [2:0]       cfg_rd_thr_i,
    input  logic             cfg_spec_en_i,
    input  logic [TMO_W-1:0] cfg_spec_tmo_i,
    input  logic [LVL_W-1:0] wr_level_i,
    input  logic [LVL_W-1:0] rd_level_i,
    input  logic             slv_wr_act_i,
    input  logic             slv_rd_act_i,
    input  logic             ob_stall_i,
    input  logic             ob_compelled_i,
    input  logic             pci_won_i,
    output logic             retry_o,
    output logic             spec_req_o,
    output logic [1:0]       state_o
);

    logic [NUM_CHAN-1:0][2:0]       thr;
    logic [NUM_CHAN-1:0][LVL_W-1:0] lvl;
    logic [NUM_CHAN-1:0]            act;
    logic                           fire;
    logic                           resolve;
    lk_state_e                      state;

    assign thr[CH_WR] = cfg_wr_thr_i;
    assign thr[CH_RD] = cfg_rd_thr_i;
    assign lvl[CH_WR] = wr_level_i;
    assign lvl[CH_RD] = rd_level_i;
    assign act[CH_WR] = slv_wr_act_i;
    assign act[CH_RD] = slv_rd_act_i;

    lkr_trigger #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) i_trigger (
        .mode_i   (cfg_mode_i),
        .thr_i    (thr),
        .level_i  (lvl),
        .active_i (act),
        .fire_o   (fire)
    );

    lkr_fsm i_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stall_i   (ob_stall_i),
        .fire_i    (fire),
        .resolve_o (resolve),
        .retry_o   (retry_o),
        .state_o   (state)
    );

    lkr_spec #(
        .TMO_W (TMO_W)
    ) i_spec (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .resolve_i   (resolve),
        .compelled_i (ob_compelled_i),
        .spec_en_i   (cfg_spec_en_i),
        .won_i       (pci_won_i),
        .tmo_i       (cfg_spec_tmo_i),
        .spec_req_o  (spec_req_o)
    );

    assign state_o = state;

    p_fire_needs_activity_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire |-> (slv_wr_act_i || slv_rd_act_i));

    p_spec_with_retry_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(spec_req_o) |-> retry_o);

    p_retry_had_stall_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        resolve |=> retry_o);

endmodule

// File: tb/test_bridge_lock_resolver.sv
`timescale 1ns/1ps
module test_bridge_lock_resolver;

    localparam int unsigned DEPTH = 16;
    localparam int unsigned TMO_W = 4;
    localparam int unsigned LVL_W = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [2:0]       wthr = 3'd0;
    logic [2:0]       rthr = 3'd0;
    logic             spec_en = 1'b0;
    logic [TMO_W-1:0] tmo = '0;
    logic [LVL_W-1:0] wlvl = '0;
    logic [LVL_W-1:0] rlvl = '0;
    logic             wact = 1'b0;
    logic             ract = 1'b0;
    logic             stall = 1'b0;
    logic             cmp = 1'b0;
    logic             won = 1'b0;
    logic             retry;
    logic             spec;
    logic [1:0]       st;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R11";
    bit    done = 1'b0;

    // Model of the expected behaviour.
    logic       m_retry = 1'b0;
    logic       m_spec = 1'b0;
    logic [1:0] m_st = 2'd0;
    int         m_cnt = 0;

    always #5 clk = ~clk;

    bridge_lock_resolver #(
        .DEPTH (DEPTH),
        .TMO_W (TMO_W)
    ) i_bridge_lock_resolver (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .cfg_mode_i     (mode),
        .cfg_wr_thr_i   (wthr),
        .cfg_rd_thr_i   (rthr),
        .cfg_spec_en_i  (spec_en),
        .cfg_spec_tmo_i (tmo),
        .wr_level_i     (wlvl),
        .rd_level_i     (rlvl),
        .slv_wr_act_i   (wact),
        .slv_rd_act_i   (ract),
        .ob_stall_i     (stall),
        .ob_compelled_i (cmp),
        .pci_won_i      (won),
        .retry_o        (retry),
        .spec_req_o     (spec),
        .state_o        (st)
    );

    function automatic bit fire_fn();
        int step = DEPTH / 8;
        case (mode)
            2'b01:   return wact || ract;
            2'b10:   return (wact && int'(wlvl) == DEPTH) || (ract && int'(rlvl) == DEPTH);
            default: return (wact && int'(wlvl) >= int'(wthr) * step)
                         || (ract && int'(rlvl) >= int'(rthr) * step);
        endcase
    endfunction

    // Advance the model by one clock edge, using the inputs as sampled at that edge.
    function automatic void model_edge();
        bit res;
        int lim;
        if (!rst_n) begin
            m_retry = 1'b0;
            m_spec  = 1'b0;
            m_st    = 2'd0;
            m_cnt   = 0;
            return;
        end
        res     = stall && fire_fn() && (m_st != 2'd2);
        m_retry = res;
        if (!stall)                        m_st = 2'd0;
        else if (res || m_st == 2'd2)      m_st = 2'd2;
        else                               m_st = 2'd1;
        lim = (tmo == 0) ? 1 : int'(tmo);
        if (res && cmp && spec_en) begin
            m_spec = 1'b1;
            m_cnt  = 0;
        end else if (m_spec) begin
            if (won || (m_cnt + 1 >= lim)) begin
                m_spec = 1'b0;
                m_cnt  = 0;
            end else begin
                m_cnt++;
            end
        end
    endfunction

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("retry", int'(retry), int'(m_retry));
        chk("spec_req", int'(spec), int'(m_spec));
        chk("state", int'(st), int'(m_st));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic quiet();
        stall = 0; cmp = 0; won = 0; wact = 0; ract = 0;
        wlvl = '0; rlvl = '0;
        run(3);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1ACE5EED));
        // R11: outputs held at reset values during reset.
        cur_req = "R11";
        stall = 1; wact = 1; mode = 2'b01;
        run(4);
        stall = 0; wact = 0; mode = 2'b00;
        rst_n = 1;
        run(2);

        // R1: write threshold 3 eighths -> 6 entries.
        cur_req = "R1";
        wthr = 3'd3; rthr = 3'd7;
        stall = 1; wact = 1; wlvl = 5'd5;
        run(3);
        wlvl = 5'd6;
        run(3);
        quiet();
        // R1: read threshold, write side idle.
        rthr = 3'd2; ract = 1; rlvl = 5'd3; stall = 1;
        run(2);
        rlvl = 5'd4;
        run(2);
        quiet();
        // R1: reserved mode 11 behaves as threshold.
        mode = 2'b11; wthr = 3'd4; wact = 1; wlvl = 5'd7; stall = 1;
        run(2);
        wlvl = 5'd8;
        run(2);
        quiet();

        // R2: any activity fires, level irrelevant.
        cur_req = "R2";
        mode = 2'b01; wthr = 3'd7; stall = 1;
        run(2);
        ract = 1;
        run(2);
        quiet();

        // R3: only full fires.
        cur_req = "R3";
        mode = 2'b10; wthr = 3'd0; wact = 1; wlvl = 5'd15; stall = 1;
        run(3);
        wlvl = 5'd16;
        run(2);
        quiet();

        // R4/R5: trigger stays true; one retry only, rearm after stall drop.
        cur_req = "R5";
        mode = 2'b01; wact = 1; stall = 1;
        run(6);
        stall = 0;
        run(1);
        stall = 1;
        run(4);
        quiet();

        // R6: trigger true but no stall.
        cur_req = "R6";
        mode = 2'b00; wthr = 3'd0; wact = 1; ract = 1; wlvl = 5'd16;
        cmp = 1; spec_en = 1;
        run(6);
        quiet();

        // R7: compelled without enable, then enable without compelled.
        cur_req = "R7";
        mode = 2'b01; wact = 1; tmo = 4'd6;
        spec_en = 0; cmp = 1; stall = 1;
        run(4);
        quiet();
        spec_en = 1; cmp = 0; wact = 1; stall = 1;
        run(4);
        quiet();
        spec_en = 1; cmp = 1; wact = 1; stall = 1;
        run(3);

        // R8: win clears the request.
        cur_req = "R8";
        won = 1;
        run(2);
        quiet();

        // R9: timeout 5, and timeout 0 behaves as 1.
        cur_req = "R9";
        tmo = 4'd5; spec_en = 1; cmp = 1; wact = 1; stall = 1;
        run(8);
        quiet();
        tmo = 4'd0; spec_en = 1; cmp = 1; wact = 1; stall = 1;
        run(4);
        quiet();

        // R10: constrained random mix across all modes.
        cur_req = "R10";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) stall = ~stall;
            if ($urandom_range(15) == 0) mode = 2'($urandom_range(3));
            if ($urandom_range(31) == 0) begin
                wthr = 3'($urandom_range(7));
                rthr = 3'($urandom_range(7));
                tmo  = TMO_W'($urandom_range(15));
                spec_en = 1'($urandom_range(1));
            end
            wlvl = LVL_W'($urandom_range(DEPTH));
            rlvl = LVL_W'($urandom_range(DEPTH));
            wact = 1'($urandom_range(1));
            ract = ($urandom_range(3) == 0);
            cmp  = 1'($urandom_range(1));
            won  = ($urandom_range(7) == 0);
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule